// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after instruction memory in a small processor front end. Each cycle it takes a six-byte window that starts at the current program counter. Byte 0 of the window is at the lowest address and is carried in bits 7:0 of the bus. From the first byte alone the block works out which class the instruction belongs to, and so how many bytes it takes. It then pulls the register specifiers and the 32-bit constant out of the bytes that follow.

The outputs are:
- the operation and variant nibbles;
- both register specifiers, with 8 standing for "no register";
- the little-endian constant;
- the length in bytes;
- the address of the next sequential instruction, which is the program counter plus the length;
- a flag for undefined operation codes.

The decode logic is combinational. A parameter puts an output register stage behind it, and that stage is on by default, so results show up one clock after the window is presented. Memory, execution, the register file and condition handling all sit outside this block.

Top module: `insn_fetch_decoder`

## Requirements
- R1: `opCode` equals bits 7:4 of byte 0 and `opVariant` equals bits 3:0 of byte 0, for every byte value including undefined codes.
- R2: Operation codes 0x0, 0x1 and 0x9 give `insnLen` 1, `regA` = `regB` = 8 and `constVal` 0.
- R3: Operation codes 0x2, 0x6, 0xA and 0xB give `insnLen` 2, `regA` = byte 1 bits 7:4, `regB` = byte 1 bits 3:0 and `constVal` 0.
- R4: Operation codes 0x3, 0x4 and 0x5 give `insnLen` 6 and take `regA`/`regB` from byte 1 as in R3. `constVal` is bytes 2..5 with byte 2 least significant, i.e. window bits 47:16.
- R5: Operation codes 0x7 and 0x8 give `insnLen` 5, `regA` = `regB` = 8, and `constVal` = bytes 1..4 with byte 1 least significant, i.e. window bits 39:8.
- R6: Bytes past the decoded length have no effect on any output.
- R7: Operation codes 0xC..0xF set `badInsn` to 1, with `insnLen` 1, `regA` = `regB` = 8 and `constVal` 0. Every other code gives `badInsn` 0.
- R8: `nextPc` equals `pcIn` + `insnLen`, modulo 2^32.
- R9: With the output stage on, every output reflects the window and PC sampled at the previous rising clock edge. While `rstN` is low the outputs read as a nop at address 0: `opCode`/`opVariant` 0, `regA`/`regB` 8, `constVal` 0, `insnLen` 1, `nextPc` 0 and `badInsn` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| pcIn | input | 32 | Address of byte 0 of the window |
| bytesIn | input | 48 | Instruction window, byte 0 in bits 7:0 |
| opCode | output | 4 | Operation nibble |
| opVariant | output | 4 | Variant nibble |
| regA | output | 4 | First register specifier, 8 if none |
| regB | output | 4 | Second register specifier, 8 if none |
| constVal | output | 32 | Immediate, displacement or destination |
| insnLen | output | 3 | Instruction length in bytes |
| nextPc | output | 32 | Address of the next sequential instruction |
| badInsn | output | 1 | Undefined operation code |

## Verification
With the default output stage, every result is due exactly one rising edge after the window and PC are applied. Inputs change on falling edges, and each output is compared at the next falling edge, which is half a period after the capturing edge. One extra check samples just after a new window is applied and confirms that the outputs still show the previous instruction, so results do not arrive early. The sweep covers all 256 first-byte values under four different tail-byte and PC patterns, and one of those patterns places the PC near 2^32 to exercise the wrap of the next address.

// File: rtl/ifd_pkg.sv
`timescale 1ns/1ps
package ifd_pkg;

  localparam int LEN_W = 3;
  localparam logic [3:0] NO_REG = 4'h8;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  // Strobes from the class decoder to the field extraction datapath.
  typedef struct packed {
    logic             isValid;
    logic             hasRegByte;
    logic             constAtOne;
    logic             constAtTwo;
    logic [LEN_W-1:0] len;
  } ifd_ctrl_t;

endpackage

// File: rtl/ifd_ctrl.sv
`timescale 1ns/1ps
module ifd_ctrl
  import ifd_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input  logic [3:0] opCode,
  output ifd_ctrl_t  strobes
);

  localparam int LEN_SHORT = 1;
  localparam int LEN_REG   = 2;
  localparam int LEN_ABS   = 1 + CONST_BYTES;
  localparam int LEN_FULL  = 2 + CONST_BYTES;

  always_comb begin
    strobes            = '0;
    strobes.isValid    = 1'b1;
    strobes.len        = LEN_W'(LEN_SHORT);
    case (opCode)
      OP_NOP, OP_HALT, OP_RET: begin
        strobes.len = LEN_W'(LEN_SHORT);
      end
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: begin
        strobes.hasRegByte = 1'b1;
        strobes.len        = LEN_W'(LEN_REG);
      end
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        strobes.hasRegByte = 1'b1;
        strobes.constAtTwo = 1'b1;
        strobes.len        = LEN_W'(LEN_FULL);
      end
      OP_JUMP, OP_CALL: begin
        strobes.constAtOne = 1'b1;
        strobes.len        = LEN_W'(LEN_ABS);
      end
      default: begin
        strobes.isValid = 1'b0;
        strobes.len     = LEN_W'(LEN_SHORT);
      end
    endcase
  end

endmodule

// File: rtl/ifd_dpath.sv
`timescale 1ns/1ps
module ifd_dpath
  import ifd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CONST_BYTES = 4,
  localparam int WIN_BYTES  = CONST_BYTES + 2,
  localparam int CONST_W    = 8 * CONST_BYTES
) (
  input  logic [8*WIN_BYTES-1:0] window,
  input  logic [ADDR_W-1:0]      pc,
  input  ifd_ctrl_t              strobes,
  output logic [3:0]             opCode,
  output logic [3:0]             opVariant,
  output logic [3:0]             regA,
  output logic [3:0]             regB,
  output logic [CONST_W-1:0]     constVal,
  output logic [LEN_W-1:0]       insnLen,
  output logic [ADDR_W-1:0]      nextPc,
  output logic                   badInsn
);

  logic [7:0]         winByte [WIN_BYTES];
  logic [CONST_W-1:0] constFromOne;
  logic [CONST_W-1:0] constFromTwo;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_split
    assign winByte[b] = window[8*b +: 8];
  end

  // Little-endian gather: lowest-address byte lands in the low bits.
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
    assign constFromOne[8*k +: 8] = winByte[1 + k];
    assign constFromTwo[8*k +: 8] = winByte[2 + k];
  end

  always_comb begin
    opCode    = winByte[0][7:4];
    opVariant = winByte[0][3:0];
    regA      = strobes.hasRegByte ? winByte[1][7:4] : NO_REG;
    regB      = strobes.hasRegByte ? winByte[1][3:0] : NO_REG;
    if (strobes.constAtTwo)      constVal = constFromTwo;
    else if (strobes.constAtOne) constVal = constFromOne;
    else                         constVal = '0;
    insnLen   = strobes.len;
    nextPc    = pc + ADDR_W'(strobes.len);
    badInsn   = ~strobes.isValid;
  end

endmodule

// File: rtl/insn_fetch_decoder.sv
`timescale 1ns/1ps
module insn_fetch_decoder
  import ifd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CONST_BYTES = 4,
  parameter bit REG_OUT     = 1'b1,
  localparam int WIN_BYTES  = CONST_BYTES + 2,
  localparam int CONST_W    = 8 * CONST_BYTES
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      pcIn,
  input  logic [8*WIN_BYTES-1:0] bytesIn,
  output logic [3:0]             opCode,
  output logic [3:0]             opVariant,
  output logic [3:0]             regA,
  output logic [3:0]             regB,
  output logic [CONST_W-1:0]     constVal,
  output logic [LEN_W-1:0]       insnLen,
  output logic [ADDR_W-1:0]      nextPc,
  output logic                   badInsn
);

  ifd_ctrl_t          strobes;
  logic [3:0]         dOp, dVar, dRegA, dRegB;
  logic [CONST_W-1:0] dConst;
  logic [LEN_W-1:0]   dLen;
  logic [ADDR_W-1:0]  dNext;
  logic               dBad;

  ifd_ctrl #(.CONST_BYTES(CONST_BYTES)) u_ctrl (
    .opCode  (bytesIn[7:4]),
    .strobes (strobes)
  );

  ifd_dpath #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) u_dpath (
    .window    (bytesIn),
    .pc        (pcIn),
    .strobes   (strobes),
    .opCode    (dOp),
    .opVariant (dVar),
    .regA      (dRegA),
    .regB      (dRegB),
    .constVal  (dConst),
    .insnLen   (dLen),
    .nextPc    (dNext),
    .badInsn   (dBad)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opCode    <= '0;
        opVariant <= '0;
        regA      <= NO_REG;
        regB      <= NO_REG;
        constVal  <= '0;
        insnLen   <= LEN_W'(1);
        nextPc    <= '0;
        badInsn   <= 1'b0;
      end else begin
        opCode    <= dOp;
        opVariant <= dVar;
        regA      <= dRegA;
        regB      <= dRegB;
        constVal  <= dConst;
        insnLen   <= dLen;
        nextPc    <= dNext;
        badInsn   <= dBad;
      end
    end
  end else begin : g_comb
    assign opCode    = dOp;
    assign opVariant = dVar;
    assign regA      = dRegA;
    assign regB      = dRegB;
    assign constVal  = dConst;
    assign insnLen   = dLen;
    assign nextPc    = dNext;
    assign badInsn   = dBad;
  end

endmodule

// File: rtl/ifd_checker.sv
`timescale 1ns/1ps
module ifd_checker #(
  parameter int ADDR_W  = 32,
  parameter int WIN_W   = 48,
  parameter int CONST_W = 32,
  parameter int LEN_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  pcIn,
  input logic [WIN_W-1:0]   bytesIn,
  input logic [3:0]         opCode,
  input logic [3:0]         regA,
  input logic [3:0]         regB,
  input logic [CONST_W-1:0] constVal,
  input logic [LEN_W-1:0]   insnLen,
  input logic [ADDR_W-1:0]  nextPc,
  input logic               badInsn
);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R7
  bad_len_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    badInsn |-> (insnLen == LEN_W'(1) && regA == 4'h8 && constVal == '0));

  // R2
  short_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h0 || opCode == 4'h1 || opCode == 4'h9) |-> (insnLen == LEN_W'(1) && !badInsn));

  // R5
  abs_no_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h7 || opCode == 4'h8) |-> (regA == 4'h8 && regB == 4'h8 && insnLen == LEN_W'(5)));

  // R3
  reg_only_const_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insnLen == LEN_W'(2)) |-> (constVal == '0));

  // R8
  next_pc_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (REG_OUT && primed) |-> (nextPc == $past(pcIn) + ADDR_W'(insnLen)));

  // R9
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (REG_OUT && primed) |-> (opCode == $past(bytesIn[7:4])));

endmodule

bind insn_fetch_decoder ifd_checker #(
  .ADDR_W(ADDR_W), .WIN_W(8*WIN_BYTES), .CONST_W(CONST_W),
  .LEN_W(ifd_pkg::LEN_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rstN(rstN), .pcIn(pcIn), .bytesIn(bytesIn),
  .opCode(opCode), .regA(regA), .regB(regB), .constVal(constVal),
  .insnLen(insnLen), .nextPc(nextPc), .badInsn(badInsn)
);

// File: tb/sim_insn_fetch_decoder.sv
`timescale 1ns/1ps
module sim_insn_fetch_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pcIn = '0;
  logic [47:0] bytesIn = '0;
  logic [3:0]  opCode, opVariant, regA, regB;
  logic [31:0] constVal, nextPc;
  logic [2:0]  insnLen;
  logic        badInsn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  insn_fetch_decoder u0 (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .bytesIn(bytesIn),
    .opCode(opCode), .opVariant(opVariant), .regA(regA), .regB(regB),
    .constVal(constVal), .insnLen(insnLen), .nextPc(nextPc), .badInsn(badInsn)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expect_all(input logic [47:0] w, input logic [31:0] pc);
    logic [3:0]  op, eA, eB;
    logic [31:0] eC;
    int          eLen;
    bit          eBad;
    string       tag;
    op = w[7:4]; eA = 4'h8; eB = 4'h8; eC = '0; eLen = 1; eBad = 0;
    case (op)
      4'h0, 4'h1, 4'h9: tag = "R2";
      4'h2, 4'h6, 4'hA, 4'hB: begin
        tag = "R3"; eLen = 2; eA = w[15:12]; eB = w[11:8];
      end
      4'h3, 4'h4, 4'h5: begin
        tag = "R4"; eLen = 6; eA = w[15:12]; eB = w[11:8]; eC = w[47:16];
      end
      4'h7, 4'h8: begin
        tag = "R5"; eLen = 5; eC = w[39:8];
      end
      default: begin tag = "R7"; eBad = 1; end
    endcase
    check("R1", "opCode", 32'(opCode), 32'(op));
    check("R1", "opVariant", 32'(opVariant), 32'(w[3:0]));
    check(tag, "insnLen", 32'(insnLen), 32'(eLen));
    check(tag, "regA", 32'(regA), 32'(eA));
    check(tag, "regB", 32'(regB), 32'(eB));
    check(tag, "constVal", constVal, eC);
    check("R7", "badInsn", 32'(badInsn), 32'(eBad));
    check("R8", "nextPc", nextPc, pc + 32'(eLen));
  endtask

  function automatic logic [47:0] mkWindow(input int b0, input int v);
    logic [47:0] w;
    w[7:0] = 8'(b0);
    for (int k = 1; k < 6; k++) w[8*k +: 8] = 8'(b0 * (13 + k) + k * 37 + v * 91 + 5);
    return w;
  endfunction

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [47:0] w;
    logic [31:0] pc;
    bytesIn = 48'h0000_1234_5678_93C5;
    pcIn    = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "reset opCode", 32'(opCode), 0);
    check("R9", "reset regA", 32'(regA), 8);
    check("R9", "reset regB", 32'(regB), 8);
    check("R9", "reset insnLen", 32'(insnLen), 1);
    check("R9", "reset nextPc", nextPc, 0);
    check("R9", "reset constVal", constVal, 0);
    check("R9", "reset badInsn", 32'(badInsn), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      for (int b0 = 0; b0 < 256; b0++) begin
        w  = mkWindow(b0, v);
        pc = (v == 3) ? (32'hFFFF_FFFF - 32'(b0 % 6)) : (32'h0000_1000 * 32'(v + 1) + 32'(b0 * 3));
        bytesIn = w;
        pcIn    = pc;
        @(negedge clk);
        expect_all(w, pc);
        // R6: rewrite bytes past the decoded length, result must not move
        if (b0 == 8'h05 || b0 == 8'h20 || b0 == 8'h71) begin
          int keep;
          keep = (b0 == 8'h05) ? 1 : (b0 == 8'h20) ? 2 : 5;
          for (int k = keep; k < 6; k++) w[8*k +: 8] = ~w[8*k +: 8];
          bytesIn = w;
          @(negedge clk);
          check("R6", "constVal after tail change", constVal, (b0 == 8'h71) ? w[39:8] : 32'h0);
          check("R6", "regA after tail change", 32'(regA), (b0 == 8'h20) ? 32'(w[15:12]) : 32'h8);
          check("R6", "insnLen after tail change", 32'(insnLen), 32'(keep));
        end
      end
    end
    // R9 latency: new window applied, outputs hold until the next rising edge
    bytesIn = 48'h0000_0000_0000_C0;
    @(negedge clk);
    check("R9", "opCode after edge", 32'(opCode), 32'hC);
    bytesIn = 48'h0000_0000_0000_61;
    #2;
    check("R9", "opCode before edge", 32'(opCode), 32'hC);
    @(negedge clk);
    check("R9", "opCode one edge later", 32'(opCode), 32'h6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule